// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block produces the pin timing of an 8-bit controller's external memory interface, where the low address byte and the data byte share one port. It runs from the oscillator clock, so one clock equals one oscillator period. A free-running counter divides time into machine cycles of twelve clocks, and each machine cycle holds two six-clock slots. Every slot starts with a two-clock address-latch strobe (`ale`). The low address is driven on the shared port while the strobe is high and for one clock after it falls.

The core asks for an access by raising `req` with a kind, an address and, for a write, a data byte. The request is taken on the last clock of a slot and runs from the next slot boundary:

- A code fetch fills one slot and uses the active-low program strobe `psen_n`.
- A data read or write fills two slots and uses `rd_n` or `wr_n`. The second slot's address strobe is suppressed.

A one-clock `done` pulse marks the end of each access, and for fetches and reads `rdata` holds the byte captured from `ad_in`. Two strobes tell the I/O ports when to sample their inputs and when to update their outputs.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high: `ale`=1, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `ad_out`=8'hFF, `a_hi` is all ones, `rdata`=8'h00, and `done`, `grant`, `port_sample` and `port_update` are 0.
- R2: The first clock after reset release is clock 0 of an idle slot. Outside data accesses, `ale` is high for 2 clocks in every 6, in slot clocks 0 and 1.
- R3: A data read or write lasts 12 clocks (steps 0 to 11). It carries exactly one `ale` pulse, in steps 0 and 1, and `ale` stays low in steps 6 and 7.
- R4: Code fetch (`req_kind` 2'b00, and also 2'b11) lasts 6 clocks. `psen_n` is low in steps 3 to 5 only. `ad_oe`=1 with `ad_out` equal to the low address byte in steps 0 to 2, and the port is released (`ad_oe`=0, `ad_out`=8'hFF) in steps 3 to 5. The value of `ad_in` in step 5 appears on `rdata` at the end of the access.
- R5: Data read (`req_kind` 2'b01): `rd_n` is low in steps 5 to 10 and `psen_n` stays high. The low address is driven in steps 0 to 2 and the port is released from step 3. The value of `ad_in` in step 10 appears on `rdata`.
- R6: Data write (`req_kind` 2'b10): `wr_n` is low in steps 5 to 10 and `psen_n` stays high. The low address is driven in steps 0 to 2, the port is released in step 3, and the write byte is driven in steps 4 to 11. `rdata` is left unchanged.
- R7: `a_hi` equals the upper address bits of the request for every step of its access.
- R8: `grant` is high only in the last clock of a slot, when `req` is high and no data access is halfway through. Kind, address and write data are taken at that edge. `done` is a one-clock pulse in the first clock after the access ends.
- R9: `port_sample` is high in clocks 9, 21, 33, … after reset release, and `port_update` two clocks after each of these.
- R10: `rd_n` and `wr_n` are never low together, and `psen_n` is high whenever either of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, held until granted |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 fetch |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8 | Byte to write |
| grant | output | 1 | Request taken at this clock edge |
| done | output | 1 | Access finished (one clock) |
| rdata | output | 8 | Byte captured by the last fetch or read |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared address/data port, output value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared address/data port, input value |
| a_hi | output | ADDR_W-8 | Upper address bits |
| port_sample | output | 1 | I/O port input sampling point |
| port_update | output | 1 | I/O port output update point |

## Verification
The bench builds the block with its default `ADDR_W` of 16. At that width every address bit, including both ends of the upper byte, is covered by table vectors such as 16'hFF00, 16'h00FF and 16'h8001. Its bus model drives `ad_in` with the expected byte only while `psen_n` or `rd_n` is low. This exposes a capture taken on the wrong step. Because the width is the real one, a request held through a read can be watched being refused at the mid-access slot boundary and granted at the end, with the write following at once with no idle slot between the two accesses.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              grant,
  output logic              done,
  output logic [7:0]        rdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic [ADDR_W-9:0] a_hi,
  output logic              port_sample,
  output logic              port_update
);

  localparam logic [3:0] MC_LAST = 4'd11;
  localparam logic [3:0] SLOT_END = 4'd5;

  typedef enum logic [1:0] {K_IDLE, K_FETCH, K_READ, K_WRITE} kind_t;

  logic [3:0]        mc, step;
  kind_t             kind, new_kind;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              bnd, is_data, hold, data_win, addr_ph, wr_ph;

  assign bnd     = (mc == SLOT_END) || (mc == MC_LAST);
  assign is_data = (kind == K_READ) || (kind == K_WRITE);
  assign hold    = is_data && (step == SLOT_END);
  assign grant   = !rst && bnd && req && !hold;

  always_comb begin
    case (req_kind)
      2'b01:   new_kind = K_READ;
      2'b10:   new_kind = K_WRITE;
      default: new_kind = K_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc      <= '0;
      step    <= '0;
      kind    <= K_IDLE;
      addr_q  <= '1;
      wdata_q <= '1;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      mc   <= (mc == MC_LAST) ? 4'd0 : mc + 4'd1;
      done <= bnd && (kind != K_IDLE) && !hold;
      if ((kind == K_FETCH && step == 4'd5) || (kind == K_READ && step == 4'd10))
        rdata <= ad_in;
      if (!bnd || hold) begin
        step <= step + 4'd1;
      end else begin
        step <= '0;
        if (grant) begin
          kind    <= new_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end else begin
          kind <= K_IDLE;
        end
      end
    end
  end

  assign data_win = (step >= 4'd5) && (step <= 4'd10);
  assign addr_ph  = (kind != K_IDLE) && (step < 4'd3);
  assign wr_ph    = (kind == K_WRITE) && (step >= 4'd4);

  assign ale    = rst || (step < 4'd2);
  assign psen_n = !(kind == K_FETCH && step >= 4'd3);
  assign rd_n   = !(kind == K_READ && data_win);
  assign wr_n   = !(kind == K_WRITE && data_win);
  assign ad_oe  = addr_ph || wr_ph;
  assign ad_out = addr_ph ? addr_q[7:0] : (wr_ph ? wdata_q : 8'hFF);
  assign a_hi   = addr_q[ADDR_W-1:8];

  assign port_sample = !rst && (mc == 4'd9);
  assign port_update = !rst && (mc == MC_LAST);

  AST_ALE_TWO_CLOCKS: assert property (@(posedge clk) disable iff (rst) $rose(ale) |=> ale ##1 !ale); // R2
  AST_AHI_STABLE: assert property (@(posedge clk) disable iff (rst) !ale |-> $stable(a_hi)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_PORT_ORDER: assert property (@(posedge clk) disable iff (rst) port_sample |-> ##2 port_update); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R10
  AST_PSEN_QUIET: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> psen_n); // R10
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst) $rose(wr_n) |-> ad_oe && ad_out == $past(ad_out)); // R6

endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic [7:0] bus_val = 8'h0;
  logic grant, done, ale, psen_n, rd_n, wr_n, ad_oe, port_sample, port_update;
  logic [7:0] rdata, ad_out, ad_in, a_hi;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign ad_in = (!psen_n || !rd_n) ? bus_val : 8'hC3;

  ext_bus_seq #(.ADDR_W(16)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .grant(grant), .done(done), .rdata(rdata), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .a_hi(a_hi), .port_sample(port_sample), .port_update(port_update)
  );

  // {kind, addr, wdata, bus byte}
  localparam logic [33:0] VEC [6] = '{
    {2'b00, 16'h1234, 8'h00, 8'hA5},
    {2'b01, 16'hBEEF, 8'h00, 8'h3C},
    {2'b10, 16'h00FF, 8'h96, 8'h00},
    {2'b11, 16'hFF00, 8'h00, 8'h81},
    {2'b10, 16'h8001, 8'h00, 8'h00},
    {2'b01, 16'h7F80, 8'h00, 8'hFF}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_grant();
    bit got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = grant;
    end
  endtask

  task automatic run_access(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] din);
    logic [7:0] rprev;
    bit fetch, isw, isr;
    int n;
    fetch = (k == 2'b00) || (k == 2'b11);
    isw = (k == 2'b10);
    isr = (k == 2'b01);
    n = fetch ? 6 : 12;
    bus_val = din; req_kind = k; req_addr = a; req_wdata = wd; req = 1'b1;
    wait_grant();
    rprev = rdata;
    @(negedge clk);
    req = 1'b0;
    for (int s = 0; s < n; s++) begin
      bit e_oe;
      logic [7:0] e_ad;
      if (s > 0) @(negedge clk);
      e_oe = (s < 3) || (isw && s >= 4);
      e_ad = (s < 3) ? a[7:0] : ((isw && s >= 4) ? wd : 8'hFF);
      check(fetch ? "R2 ale" : "R3 ale", int'(ale), int'(s < 2));
      check("R4 psen_n", int'(psen_n), int'(!(fetch && s >= 3)));
      check("R5 rd_n", int'(rd_n), int'(!(isr && s >= 5 && s <= 10)));
      check("R6 wr_n", int'(wr_n), int'(!(isw && s >= 5 && s <= 10)));
      check(fetch ? "R4 port" : (isw ? "R6 port" : "R5 port"), int'({ad_oe, ad_out}), int'({e_oe, e_ad}));
      check("R7 a_hi", int'(a_hi), int'(a[15:8]));
      check("R10 strobes", int'((rd_n || wr_n) && ((rd_n && wr_n) || psen_n)), 1);
      if (s > 0) check("R8 done low", int'(done), 0);
    end
    @(negedge clk);
    check("R8 done", int'(done), 1);
    if (isw) check("R6 rdata kept", int'(rdata), int'(rprev));
    else check(fetch ? "R4 rdata" : "R5 rdata", int'(rdata), int'(din));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ale", int'(ale), 1);
    check("R1 strobes", int'({psen_n, rd_n, wr_n}), 3'b111);
    check("R1 port", int'({ad_oe, ad_out}), 9'h0FF);
    check("R1 a_hi", int'(a_hi), 8'hFF);
    check("R1 rdata", int'(rdata), 0);
    check("R1 pulses", int'({done, grant, port_sample, port_update}), 0);
    rst = 1'b0;
    // R2 / R9 idle timing, index i is clock i+1 after release
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R2 idle ale", int'(ale), int'(((i + 1) % 6) < 2));
      check("R9 port_sample", int'(port_sample), int'(((i + 1) % 12) == 9));
      check("R9 port_update", int'(port_update), int'(((i + 1) % 12) == 11));
    end
    // table walk
    foreach (VEC[j]) run_access(VEC[j][33:32], VEC[j][31:16], VEC[j][15:8], VEC[j][7:0]);
    // R8 grant refused mid data access, then back-to-back write
    bus_val = 8'h5E; req_kind = 2'b01; req_addr = 16'h4411; req = 1'b1;
    wait_grant();
    @(negedge clk);
    req_kind = 2'b10; req_addr = 16'h2299; req_wdata = 8'h6D;
    for (int s = 1; s < 12; s++) begin
      @(negedge clk);
      if (s == 5) check("R8 grant held off", int'(grant), 0);
      if (s == 11) check("R8 grant at end", int'(grant), 1);
      check("R7 a_hi during read", int'(a_hi), 8'h44);
    end
    @(negedge clk);
    req = 1'b0;
    check("R8 read done", int'(done), 1);
    check("R5 read rdata", int'(rdata), 8'h5E);
    check("R3 back-to-back ale", int'(ale), 1);
    check("R7 a_hi new", int'(a_hi), 8'h22);
    for (int s = 1; s < 12; s++) begin
      @(negedge clk);
      if (s == 4) check("R6 write data", int'({ad_oe, ad_out}), int'({1'b1, 8'h6D}));
      if (s == 7) check("R6 wr_n low", int'(wr_n), 0);
    end
    @(negedge clk);
    check("R8 write done", int'(done), 1);
    check("R6 rdata kept", int'(rdata), 8'h5E);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule